// File: doc/BRIEF.md
# Stereo PDM Microphone Clock Generator and Channel Capture

This block drives the clock for two digital PDM microphones that share a single data wire, and splits that wire into left and right one-bit streams. The microphone clock comes only from the system bit clock. It is that clock divided by 8 for the higher sample-rate family (44.1 kHz and up) or by 12 for the lower family (32 kHz and below). Because there is no other time source, any ppm offset on the bit clock shows up on the microphone clock unchanged.

The two microphones take turns on the data wire. One channel is sampled at the bit-clock edge that raises the microphone clock, and the other at the edge that lowers it. Each captured bit is held on its own channel output and marked by a single-cycle strobe. A parameter chooses which microphone-clock edge belongs to the left channel. An enable input stops the clock (held low) and the strobes. A new rate-select value is only adopted at a period boundary, so the microphone never sees a shortened or stretched cycle.

Top module: `pdm_stereo_capture`

## Requirements
- R1: With `rate_low_i` = 0, the microphone clock period is DIV_FAST (default 8) bit-clock cycles, high for the first half of the period and low for the second half (4/4).
- R2: With `rate_low_i` = 1, the microphone clock period is DIV_SLOW (default 12) bit-clock cycles, split evenly high and low (6/6).
- R3: The divide ratio is sampled only at the bit-clock edge that begins a period. A rate-select change inside a period leaves that period's length and shape untouched, and the next period uses the new ratio.
- R4: At the bit-clock edge that raises the microphone clock, the value on `mic_data_i` is captured. With LEFT_ON_RISE = 1 it appears on `left_bit_o`, and `left_valid_o` is high for exactly the cycle after that edge.
- R5: At the bit-clock edge that lowers the microphone clock, `mic_data_i` is captured. With LEFT_ON_RISE = 1 it appears on `right_bit_o`, with `right_valid_o` high for that one cycle.
- R6: With LEFT_ON_RISE = 0 the edges swap: the left channel is captured on the falling edge and the right channel on the rising edge.
- R7: Each valid strobe lasts one bit-clock cycle and fires once per microphone-clock period. Left and right strobes are never high together, and a strobe never fires without a matching microphone-clock edge.
- R8: While `enable_i` is low, the microphone clock is low from the next bit-clock edge on, no strobes fire, and the divider is held. The first edge with `enable_i` high starts a fresh period: the clock rises, the rising-edge channel is captured, and the divide ratio is taken from `rate_low_i` at that edge.
- R9: Synchronous reset (`rst_i` high) clears the divider, drives the microphone clock low, and clears both channel bits and both strobes.
- R10: A channel bit output keeps its last captured value until that channel's next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System bit clock; every register uses its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Runs the microphone clock and capture when high |
| rate_low_i | input | 1 | 0 selects divide-by-DIV_FAST, 1 selects divide-by-DIV_SLOW |
| mic_data_i | input | 1 | Shared PDM data line from both microphones |
| mic_clk_o | output | 1 | Registered microphone clock |
| left_bit_o | output | 1 | Latest left-channel bit |
| left_valid_o | output | 1 | One-cycle strobe for a new left bit |
| right_bit_o | output | 1 | Latest right-channel bit |
| right_valid_o | output | 1 | One-cycle strobe for a new right bit |

## Verification
The bench builds two copies side by side with the default 8/12 divide ratios. One copy has LEFT_ON_RISE = 1 and the other has LEFT_ON_RISE = 0, and both receive the same stimulus, so the swapped channel mapping is checked against the same data as the default one. Between sampling points the data line is driven to the opposite of the expected bit, so a capture one cycle early or late produces a wrong bit. The stimulus covers rate changes in the middle of a period, enable dropping before and after the falling edge, and restarts from idle at both rates.

// File: rtl/pdm_cap_pkg.sv
package pdm_cap_pkg;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } mic_edge_e;

    typedef struct packed {
        logic data_bit;
        logic strobe;
    } chan_out_t;

    function automatic int half_of(input int ratio);
        return ratio / 2;
    endfunction

endpackage

// File: rtl/pdm_clk_div.sv
module pdm_clk_div
    import pdm_cap_pkg::*;
#(
    parameter int DIV_FAST = 8,
    parameter int DIV_SLOW = 12
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      enable_i,
    input  logic      rate_low_i,
    output logic      mic_clk_o,
    output mic_edge_e edge_evt_o
);
    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int DIV_W   = $clog2(DIV_MAX + 1);

    logic [DIV_W-1:0] count_q, count_d;
    logic [DIV_W-1:0] ratio_q, ratio_d;
    logic [DIV_W-1:0] ratio_req;
    logic             running_q;
    logic             mic_clk_q;
    logic             at_last, begin_period;
    mic_edge_e        edge_d;

    assign ratio_req = rate_low_i ? DIV_W'(DIV_SLOW) : DIV_W'(DIV_FAST);

    always_comb begin
        at_last      = running_q && (count_q == ratio_q - 1'b1);
        begin_period = enable_i && (!running_q || at_last);
        ratio_d      = begin_period ? ratio_req : ratio_q;
        if (!enable_i || begin_period)
            count_d = '0;
        else
            count_d = count_q + 1'b1;
        if (begin_period)
            edge_d = EDGE_RISE;
        else if (enable_i && running_q &&
                 (int'(count_q) + 1 == half_of(int'(ratio_q))))
            edge_d = EDGE_FALL;
        else
            edge_d = EDGE_NONE;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            count_q   <= '0;
            ratio_q   <= DIV_W'(DIV_FAST);
            running_q <= 1'b0;
            mic_clk_q <= 1'b0;
        end else begin
            count_q   <= count_d;
            ratio_q   <= ratio_d;
            running_q <= enable_i;
            mic_clk_q <= enable_i && (int'(count_d) < half_of(int'(ratio_d)));
        end
    end

    assign mic_clk_o  = mic_clk_q;
    assign edge_evt_o = edge_d;

    assert_ratio_at_boundary_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(ratio_q) |-> (count_q == '0));

    assert_rise_starts_period_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(mic_clk_q) |-> (count_q == '0));

    assert_fall_at_half_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ($fell(mic_clk_q) && running_q) |-> (int'(count_q) == half_of(int'(ratio_q))));

    assert_idle_clock_low_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !enable_i |=> !mic_clk_q);

    assert_count_in_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        running_q |-> (count_q < ratio_q));

endmodule

// File: rtl/pdm_edge_latch.sv
module pdm_edge_latch
    import pdm_cap_pkg::*;
#(
    parameter mic_edge_e CAP_EDGE = EDGE_RISE
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  mic_edge_e edge_evt_i,
    input  logic      data_i,
    output chan_out_t chan_o
);
    chan_out_t chan_q;
    logic      hit;

    assign hit = (edge_evt_i == CAP_EDGE);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chan_q <= '0;
        end else begin
            chan_q.strobe <= hit;
            if (hit)
                chan_q.data_bit <= data_i;
        end
    end

    assign chan_o = chan_q;

    assert_hold_between_strobes_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        !hit |=> $stable(chan_q.data_bit));

    assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        chan_q.strobe |=> !chan_q.strobe);

endmodule

// File: rtl/pdm_stereo_capture.sv
module pdm_stereo_capture
    import pdm_cap_pkg::*;
#(
    parameter int DIV_FAST     = 8,
    parameter int DIV_SLOW     = 12,
    parameter bit LEFT_ON_RISE = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic enable_i,
    input  logic rate_low_i,
    input  logic mic_data_i,
    output logic mic_clk_o,
    output logic left_bit_o,
    output logic left_valid_o,
    output logic right_bit_o,
    output logic right_valid_o
);
    localparam mic_edge_e LEFT_EDGE  = LEFT_ON_RISE ? EDGE_RISE : EDGE_FALL;
    localparam mic_edge_e RIGHT_EDGE = LEFT_ON_RISE ? EDGE_FALL : EDGE_RISE;

    mic_edge_e edge_evt;
    chan_out_t left_c, right_c;

    pdm_clk_div #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW)
    ) u_div (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .enable_i   (enable_i),
        .rate_low_i (rate_low_i),
        .mic_clk_o  (mic_clk_o),
        .edge_evt_o (edge_evt)
    );

    pdm_edge_latch #(.CAP_EDGE(LEFT_EDGE)) u_left (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .edge_evt_i (edge_evt),
        .data_i     (mic_data_i),
        .chan_o     (left_c)
    );

    pdm_edge_latch #(.CAP_EDGE(RIGHT_EDGE)) u_right (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .edge_evt_i (edge_evt),
        .data_i     (mic_data_i),
        .chan_o     (right_c)
    );

    assign left_bit_o    = left_c.data_bit;
    assign left_valid_o  = left_c.strobe;
    assign right_bit_o   = right_c.data_bit;
    assign right_valid_o = right_c.strobe;

    assert_strobes_exclusive_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !(left_valid_o && right_valid_o));

    assert_left_edge_map_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        left_valid_o |-> (mic_clk_o == LEFT_ON_RISE));

    assert_right_edge_map_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        right_valid_o |-> (mic_clk_o != LEFT_ON_RISE));

    assert_strobe_needs_edge_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (left_valid_o || right_valid_o) |-> !$stable(mic_clk_o));

endmodule

// File: tb/pdm_stereo_capture_bench.sv
module pdm_stereo_capture_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV8  = 8;
    localparam int DIV12 = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic rate_low = 1'b0;
    logic mic_data = 1'b0;

    logic a_clk, a_lb, a_lv, a_rb, a_rv;
    logic b_clk, b_lb, b_lv, b_rb, b_rv;

    int checks = 0;
    int errors = 0;
    bit started = 1'b0;
    bit finished = 1'b0;
    logic exp_clk = 1'b0;
    string clk_req = "R9";

    bit exp_q [4][$];
    logic last_bit [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    pdm_stereo_capture #(.DIV_FAST(DIV8), .DIV_SLOW(DIV12), .LEFT_ON_RISE(1'b1)) u_pdm_stereo_capture (
        .clk_i(clk), .rst_i(rst), .enable_i(en), .rate_low_i(rate_low), .mic_data_i(mic_data),
        .mic_clk_o(a_clk), .left_bit_o(a_lb), .left_valid_o(a_lv),
        .right_bit_o(a_rb), .right_valid_o(a_rv));

    pdm_stereo_capture #(.DIV_FAST(DIV8), .DIV_SLOW(DIV12), .LEFT_ON_RISE(1'b0)) u_pdm_stereo_capture_swap (
        .clk_i(clk), .rst_i(rst), .enable_i(en), .rate_low_i(rate_low), .mic_data_i(mic_data),
        .mic_clk_o(b_clk), .left_bit_o(b_lb), .left_valid_o(b_lv),
        .right_bit_o(b_rb), .right_valid_o(b_rv));

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // monitor side of the scoreboard: queue 0 a-left, 1 a-right, 2 b-left, 3 b-right
    task automatic mon_chan(input int k, input string req, input logic v, input logic b);
        if (v === 1'b1) begin
            checks++;
            if (exp_q[k].size() == 0) begin
                errors++;
                $display("FAIL R7 stream %0d: actual=strobe expected=no strobe at %0t", k, $time);
            end else begin
                bit e;
                e = exp_q[k].pop_front();
                if (b !== e) begin
                    errors++;
                    $display("FAIL %s stream %0d bit: actual=%b expected=%b at %0t", req, k, b, e, $time);
                end
            end
            last_bit[k] = b;
        end else begin
            check("R10", "held bit", b, last_bit[k]);
        end
    endtask

    always @(negedge clk) begin
        if (started && !finished) begin
            mon_chan(0, "R4", a_lv, a_lb);
            mon_chan(1, "R5", a_rv, a_rb);
            mon_chan(2, "R6", b_lv, b_lb);
            mon_chan(3, "R6", b_rv, b_rb);
        end
    end

    // driver side: one bit-clock cycle of stimulus, after checking the clock shape
    task automatic drive_cycle(input logic en_v, input logic rate_v, input logic d);
        @(negedge clk);
        check(clk_req, "mic clock (default map)", a_clk, exp_clk);
        check(clk_req, "mic clock (swapped map)", b_clk, exp_clk);
        en = en_v;
        rate_low = rate_v;
        mic_data = d;
    endtask

    task automatic run_period(input bit rate_now, input bit rate_next,
                              input bit l, input bit r, input int stop_at);
        int div;
        int half;
        div = rate_now ? DIV12 : DIV8;
        half = div / 2;
        for (int j = 0; j < stop_at && j < div; j++) begin
            logic d;
            if (j == 0) d = l;
            else if (j == half) d = r;
            else if (j < half) d = ~l;
            else d = ~r;
            drive_cycle(1'b1, (j == 0) ? rate_now : rate_next, d);
            clk_req = rate_now ? "R2" : "R1";
            exp_clk = (j < half);
            if (j == 0) begin
                exp_q[0].push_back(l);
                exp_q[3].push_back(l);
            end
            if (j == half) begin
                exp_q[1].push_back(r);
                exp_q[2].push_back(r);
            end
        end
    endtask

    task automatic idle(input int n, input bit rate_v);
        for (int j = 0; j < n; j++) begin
            drive_cycle(1'b0, rate_v, j[0]);
            exp_clk = 1'b0;
            clk_req = "R8";
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit rates [18];
        logic [7:0] lfsr;
        for (int k = 0; k < 4; k++) last_bit[k] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: reset state of both copies
        check("R9", "mic clock a", a_clk, 1'b0);
        check("R9", "mic clock b", b_clk, 1'b0);
        check("R9", "left bit", a_lb, 1'b0);
        check("R9", "right bit", a_rb, 1'b0);
        check("R9", "left valid", a_lv, 1'b0);
        check("R9", "right valid", a_rv, 1'b0);
        check("R9", "swap left valid", b_lv, 1'b0);
        check("R9", "swap right valid", b_rv, 1'b0);
        rst = 1'b0;
        started = 1'b1;
        idle(3, 1'b0);

        // R1 R4 R5: fast family, several bit pairs
        run_period(1'b0, 1'b0, 1'b1, 1'b0, 99);
        run_period(1'b0, 1'b0, 1'b0, 1'b1, 99);
        run_period(1'b0, 1'b0, 1'b1, 1'b1, 99);
        // R3: request slow inside this period; it must stay 8 long
        run_period(1'b0, 1'b1, 1'b0, 1'b0, 99);
        // R2: slow family
        run_period(1'b1, 1'b1, 1'b1, 1'b0, 99);
        run_period(1'b1, 1'b1, 1'b0, 1'b1, 99);
        // R3: back to fast at the boundary
        run_period(1'b1, 1'b0, 1'b1, 1'b1, 99);
        run_period(1'b0, 1'b0, 1'b0, 1'b1, 99);

        // R8: enable drops before the falling edge, then restart slow from idle
        run_period(1'b0, 1'b0, 1'b1, 1'b1, 3);
        idle(6, 1'b1);
        run_period(1'b1, 1'b1, 1'b0, 1'b1, 99);
        // R8: enable drops after the falling edge
        run_period(1'b1, 1'b1, 1'b1, 1'b0, 8);
        idle(5, 1'b0);

        // mixed sequence with rate changes at many boundaries
        lfsr = 8'hA5;
        for (int i = 0; i < 18; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            rates[i] = lfsr[2];
        end
        idle(2, rates[0]);
        for (int i = 0; i < 17; i++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            run_period(rates[i], rates[i+1], lfsr[0], lfsr[1], 99);
        end
        idle(6, 1'b0);

        // R7: every expected strobe was seen, and none was left over
        for (int k = 0; k < 4; k++) begin
            checks++;
            if (exp_q[k].size() != 0) begin
                errors++;
                $display("FAIL R7 stream %0d pending: actual=%0d expected=0", k, exp_q[k].size());
            end
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule